// File: doc/BRIEF.md
# Host-Paced Remote Buffer Transfer Engine

This block lets a host move data into or out of a local packet buffer through a single data port. The host sets up a transfer in a few byte-wide registers: a start address split into a low and a high byte, a byte count split the same way, and a width selection that chooses byte or 16-bit word transfers. It then writes a read or write code into the command register. Each strobe on the data port moves one byte, or one little-endian word, and advances the address and the remaining count by the number of bytes moved.

When the count runs out, the engine returns to idle and raises a completion flag in the status register. The flag drives the `done_irq` output and is cleared by writing a one to its bit. For reads, the buffer word at the current address is fetched ahead of time, so the data port output is valid before every read strobe, including back-to-back strobes. The packet buffer is an internal byte array that the 16-bit address indexes modulo its size.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset the command field (register 0, bits 1:0) reads 00, the completion bit (register 1, bit 0) reads 0, `done_irq` is 0, and the address (registers 3 low, 4 high) and count (registers 5 low, 6 high) read 0.
- R2: In byte mode (register 2 bit 0 = 0), each accepted data-port strobe moves `dp_wdata[7:0]` into, or returns on `dp_rdata[7:0]` from, the byte at the current address; the address then rises by 1 and the count falls by 1.
- R3: Writing 01 to the command field starts a remote read and writing 10 starts a remote write. The command field reads back the active code until the transfer ends.
- R4: The strobe that brings the count to zero sets the completion bit and `done_irq` on that clock edge, and the command field returns to 00.
- R5: Writing 1 to bit 0 of the status register clears the completion bit. Writing 0 leaves it set.
- R6: During a read, `dp_rdata` holds the data at the current address before every strobe, and a new strobe may follow on the very next cycle.
- R7: In word mode (register 2 bit 0 = 1), a strobe moves two bytes: bits 7:0 go to the lower address and bits 15:8 to the next one. The address rises by 2.
- R8: In word mode an odd count ends after (count+1)/2 strobes, and the count stops at 0 without wrapping.
- R9: While the command field is idle, data-port strobes change neither the address, the count, the completion bit nor the buffer contents.
- R10: A read or write code written while a transfer is active is ignored, and the active code is kept.
- R11: Writing 00 or 11 to the command field during a transfer aborts it. The command field returns to 00, the completion bit is not set, and the address and count keep their values.
- R12: Writes to the address, count or width registers are ignored while a transfer is active.
- R13: The address counter wraps from 16'hFFFF to 16'h0000.
- R14: A read or write code issued with a count of zero sets the completion bit at once and leaves the command field at 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dp_rd | input | 1 | Data-port read strobe |
| dp_wr | input | 1 | Data-port write strobe |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data-port read data (upper byte 0 in byte mode) |
| done_irq | output | 1 | Completion flag |

## Verification
On every cycle the assertions check the counter stepping, the freezing of address and count while a transfer is active but not strobed, and that the completion flag is set on the final strobe or a zero-count start. They also check that the flag falls only after a write-one-to-clear, and that start codes written during a transfer and aborts leave the state as required. Only the bench scenarios can show that the data reaches the right bytes: that word mode keeps little-endian order across an odd count, that the prefetched read data matches what an earlier write stored, and that strobes while idle leave the buffer contents untouched.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
   typedef enum logic [1:0] {
      CMD_IDLE = 2'b00,
      CMD_RD   = 2'b01,
      CMD_WR   = 2'b10,
      CMD_STOP = 2'b11
   } cmd_e;

   localparam logic [2:0] RA_CMD    = 3'd0;
   localparam logic [2:0] RA_STAT   = 3'd1;
   localparam logic [2:0] RA_CFG    = 3'd2;
   localparam logic [2:0] RA_ADDR_L = 3'd3;
   localparam logic [2:0] RA_ADDR_H = 3'd4;
   localparam logic [2:0] RA_CNT_L  = 3'd5;
   localparam logic [2:0] RA_CNT_H  = 3'd6;
endpackage

// File: rtl/rdma_pktram.sv
module rdma_pktram #(
   parameter int RAM_AW = 8
) (
   input  logic              clk,
   input  logic              we_lo,
   input  logic              we_hi,
   input  logic [RAM_AW-1:0] waddr,
   input  logic [15:0]       wdata,
   input  logic [RAM_AW-1:0] raddr,
   output logic [15:0]       rdata
);
   localparam int DEPTH = 1 << RAM_AW;
   localparam logic [RAM_AW-1:0] ONE = RAM_AW'(1);

   logic [7:0] mem [DEPTH];
   logic [RAM_AW-1:0] waddr_hi;
   logic [RAM_AW-1:0] raddr_hi;

   assign waddr_hi = waddr + ONE;
   assign raddr_hi = raddr + ONE;

   always_ff @(posedge clk) begin
      if (we_lo) mem[waddr] <= wdata[7:0];
      if (we_hi) mem[waddr_hi] <= wdata[15:8];
   end

   // registered read at the address the counter will hold after this edge
   always_ff @(posedge clk) begin
      rdata <= {mem[raddr_hi], mem[raddr]};
   end
endmodule

// File: rtl/rdma_counters.sv
module rdma_counters #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              addr_lo_we,
   input  logic              addr_hi_we,
   input  logic              cnt_lo_we,
   input  logic              cnt_hi_we,
   input  logic [7:0]        wdata,
   input  logic              acc,
   input  logic              word_mode,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] addr_nxt,
   output logic [CNT_W-1:0]  cnt,
   output logic              cnt_zero,
   output logic              last_acc
);
   localparam int AH_W = ADDR_W - 8;
   localparam int CH_W = CNT_W - 8;

   logic [CNT_W-1:0]  cstep;
   logic [ADDR_W-1:0] astep;
   logic [CNT_W-1:0]  cnt_nxt;

   assign cstep    = word_mode ? CNT_W'(2) : CNT_W'(1);
   assign astep    = word_mode ? ADDR_W'(2) : ADDR_W'(1);
   assign last_acc = (cnt <= cstep);
   assign cnt_zero = (cnt == '0);

   always_comb begin
      addr_nxt = addr;
      if (acc) begin
         addr_nxt = addr + astep;
      end else if (!busy) begin
         if (addr_lo_we) addr_nxt = {addr[ADDR_W-1:8], wdata};
         else if (addr_hi_we) addr_nxt = {wdata[AH_W-1:0], addr[7:0]};
      end
   end

   always_comb begin
      cnt_nxt = cnt;
      if (acc) begin
         cnt_nxt = last_acc ? '0 : cnt - cstep;
      end else if (!busy) begin
         if (cnt_lo_we) cnt_nxt = {cnt[CNT_W-1:8], wdata};
         else if (cnt_hi_we) cnt_nxt = {wdata[CH_W-1:0], cnt[7:0]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
         cnt  <= '0;
      end else begin
         addr <= addr_nxt;
         cnt  <= cnt_nxt;
      end
   end

   // R12: no counter change while a transfer runs without a strobe
   a_r12_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !acc) |=> ($stable(addr) && $stable(cnt)));
   // R2 / R13: byte step, wrapping at the top of the address range
   a_r13_byte_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !word_mode) |=> (addr == $past(addr) + ADDR_W'(1)));
   // R7: word step
   a_r7_word_step: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && word_mode) |=> (addr == $past(addr) + ADDR_W'(2)));
   // R8: final strobe leaves the count at exactly zero
   a_r8_count_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && last_acc) |=> (cnt == '0));
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
   import rdma_pkg::*;
#(
   parameter bit WORD_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_we,
   input  logic [1:0] cmd_val,
   input  logic       stat_clr,
   input  logic       cfg_we,
   input  logic       cfg_word,
   input  logic       cnt_is_zero,
   input  logic       last_acc,
   input  logic       dp_rd,
   input  logic       dp_wr,
   output logic       busy,
   output logic       acc,
   output logic       wr_acc,
   output logic       word_mode,
   output logic       done,
   output logic [1:0] cmd_state
);
   cmd_e state;
   logic idle, is_start_code, start_req, abort_req, fin, zero_start;

   assign idle          = (state == CMD_IDLE);
   assign busy          = !idle;
   assign is_start_code = (cmd_val == CMD_RD) || (cmd_val == CMD_WR);
   assign start_req     = cmd_we && idle && is_start_code;
   assign abort_req     = cmd_we && !idle && !is_start_code;
   assign wr_acc        = dp_wr && (state == CMD_WR);
   assign acc           = (dp_rd && (state == CMD_RD)) || wr_acc;
   assign fin           = acc && last_acc;
   assign zero_start    = start_req && cnt_is_zero;
   assign cmd_state     = state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CMD_IDLE;
      end else if (start_req && !cnt_is_zero) begin
         state <= cmd_e'(cmd_val);
      end else if (abort_req || fin) begin
         state <= CMD_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done <= 1'b0;
      else if (fin || zero_start) done <= 1'b1;
      else if (stat_clr) done <= 1'b0;
   end

   generate
      if (WORD_EN) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_mode <= 1'b0;
            else if (cfg_we && idle) word_mode <= cfg_word;
         end
      end else begin : g_byte_only
         logic unused_cfg;
         assign unused_cfg = cfg_we ^ cfg_word;
         assign word_mode  = 1'b0;
      end
   endgenerate

   // R4: final strobe completes the transfer
   a_r4_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> (done && state == CMD_IDLE));
   // R5: write-one clears when no completion coincides
   a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !fin && !zero_start) |=> !done);
   // R5: flag only falls after a clear write
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> $past(stat_clr));
   // R10: start codes during a transfer do not alter the state
   a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && is_start_code && busy && !fin) |=> $stable(state));
   // R11: abort idles without raising the flag
   a_r11_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_req && !fin) |=> (state == CMD_IDLE && done == $past(done)));
   // R14: zero-count start completes at once
   a_r14_zero_start: assert property (@(posedge clk) disable iff (!rst_n)
      zero_start |=> (done && state == CMD_IDLE));
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
   import rdma_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int CNT_W   = 16,
   parameter int RAM_AW  = 8,
   parameter bit WORD_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [2:0]  reg_addr,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   input  logic        dp_rd,
   input  logic        dp_wr,
   input  logic [15:0] dp_wdata,
   output logic [15:0] dp_rdata,
   output logic        done_irq
);
   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr_w
         $error("ADDR_W must lie in 9..16");
      end
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt_w
         $error("CNT_W must lie in 9..16");
      end
      if (RAM_AW < 2 || RAM_AW > 12 || RAM_AW > ADDR_W) begin : g_bad_ram_aw
         $error("RAM_AW must lie in 2..12 and not exceed ADDR_W");
      end
   endgenerate

   logic              busy, acc, wr_acc, word_mode, done, cnt_zero, last_acc;
   logic [1:0]        cmd_state;
   logic [ADDR_W-1:0] addr, addr_nxt;
   logic [CNT_W-1:0]  cnt;
   logic [15:0]       ram_q;
   logic [15:0]       addr16, cnt16;

   rdma_ctrl #(.WORD_EN(WORD_EN)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_we     (reg_wr && reg_addr == RA_CMD),
      .cmd_val    (reg_wdata[1:0]),
      .stat_clr   (reg_wr && reg_addr == RA_STAT && reg_wdata[0]),
      .cfg_we     (reg_wr && reg_addr == RA_CFG),
      .cfg_word   (reg_wdata[0]),
      .cnt_is_zero(cnt_zero),
      .last_acc   (last_acc),
      .dp_rd      (dp_rd),
      .dp_wr      (dp_wr),
      .busy       (busy),
      .acc        (acc),
      .wr_acc     (wr_acc),
      .word_mode  (word_mode),
      .done       (done),
      .cmd_state  (cmd_state)
   );

   rdma_counters #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .addr_lo_we(reg_wr && reg_addr == RA_ADDR_L),
      .addr_hi_we(reg_wr && reg_addr == RA_ADDR_H),
      .cnt_lo_we (reg_wr && reg_addr == RA_CNT_L),
      .cnt_hi_we (reg_wr && reg_addr == RA_CNT_H),
      .wdata     (reg_wdata),
      .acc       (acc),
      .word_mode (word_mode),
      .addr      (addr),
      .addr_nxt  (addr_nxt),
      .cnt       (cnt),
      .cnt_zero  (cnt_zero),
      .last_acc  (last_acc)
   );

   rdma_pktram #(.RAM_AW(RAM_AW)) u_ram (
      .clk  (clk),
      .we_lo(wr_acc),
      .we_hi(wr_acc && word_mode),
      .waddr(addr[RAM_AW-1:0]),
      .wdata(dp_wdata),
      .raddr(addr_nxt[RAM_AW-1:0]),
      .rdata(ram_q)
   );

   assign addr16   = 16'(addr);
   assign cnt16    = 16'(cnt);
   assign done_irq = done;

   generate
      if (WORD_EN) begin : g_rd_word
         assign dp_rdata = word_mode ? ram_q : {8'h00, ram_q[7:0]};
      end else begin : g_rd_byte
         assign dp_rdata = {8'h00, ram_q[7:0]};
      end
   endgenerate

   always_comb begin
      unique case (reg_addr)
         RA_CMD:    reg_rdata = {6'b0, cmd_state};
         RA_STAT:   reg_rdata = {7'b0, done};
         RA_CFG:    reg_rdata = {7'b0, word_mode};
         RA_ADDR_L: reg_rdata = addr16[7:0];
         RA_ADDR_H: reg_rdata = addr16[15:8];
         RA_CNT_L:  reg_rdata = cnt16[7:0];
         RA_CNT_H:  reg_rdata = cnt16[15:8];
         default:   reg_rdata = 8'h00;
      endcase
   end

   // R9: idle strobes leave address and count alone
   a_r9_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (dp_rd || dp_wr) && !reg_wr) |=> ($stable(addr) && $stable(cnt)));
   // R3: the command field only ever holds idle, read or write
   a_r3_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_state != 2'b11);
   // R4: an active transfer always has bytes left
   a_r4_busy_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cnt_zero);
endmodule

// File: tb/sim_rdma_port_engine.sv
`timescale 1ns/1ps
module sim_rdma_port_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic        dp_rd = 1'b0;
   logic        dp_wr = 1'b0;
   logic [15:0] dp_wdata = 16'd0;
   logic [15:0] dp_rdata;
   logic        done_irq;

   int tests = 0;
   int fails = 0;
   logic [7:0] model [256];

   always #10 clk = ~clk;

   rdma_port_engine u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_rd(dp_rd),
      .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
      .done_irq(done_irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", req, got, exp);
      end
   endtask

   task automatic wreg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rreg(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic rd_addr(output logic [15:0] v);
      logic [7:0] lo, hi;
      rreg(3'd3, lo); rreg(3'd4, hi);
      v = {hi, lo};
   endtask

   task automatic rd_cnt(output logic [15:0] v);
      logic [7:0] lo, hi;
      rreg(3'd5, lo); rreg(3'd6, hi);
      v = {hi, lo};
   endtask

   task automatic setup(input logic [15:0] a, input logic [15:0] c, input logic wm);
      wreg(3'd2, {7'b0, wm});
      wreg(3'd3, a[7:0]); wreg(3'd4, a[15:8]);
      wreg(3'd5, c[7:0]); wreg(3'd6, c[15:8]);
   endtask

   task automatic dp_write(input logic [15:0] d);
      @(negedge clk);
      dp_wr = 1'b1; dp_wdata = d;
      @(negedge clk);
      dp_wr = 1'b0;
   endtask

   task automatic dp_read(output logic [15:0] d);
      @(negedge clk);
      d = dp_rdata;
      dp_rd = 1'b1;
      @(negedge clk);
      dp_rd = 1'b0;
   endtask

   task automatic expect_done(input string req, input logic [15:0] a_exp);
      logic [7:0] v; logic [15:0] w;
      chk({req, " done_irq"}, 32'(done_irq), 32'd1);
      rreg(3'd1, v); chk({req, " status"}, 32'(v), 32'd1);
      rreg(3'd0, v); chk({req, " cmd idle"}, 32'(v), 32'd0);
      rd_cnt(w);     chk({req, " count zero"}, 32'(w), 32'd0);
      rd_addr(w);    chk({req, " end addr"}, 32'(w), 32'(a_exp));
      wreg(3'd1, 8'h01);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [7:0] v; logic [15:0] w, d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rreg(3'd0, v); chk("R1 cmd", 32'(v), 0);
      rreg(3'd1, v); chk("R1 status", 32'(v), 0);
      chk("R1 done_irq", 32'(done_irq), 0);
      rd_addr(w); chk("R1 addr", 32'(w), 0);
      rd_cnt(w);  chk("R1 count", 32'(w), 0);

      // R2 R3 R4 R6 R7 R8: sweep modes, counts and bases; write then read back
      for (int wm = 0; wm < 2; wm++) begin
         for (int n = 1; n < 8; n++) begin
            logic [15:0] base;
            int nacc, stp;
            base = 16'((wm != 0 ? 16'h0081 : 16'h0010) + n * 9);
            stp  = (wm != 0) ? 2 : 1;
            nacc = (wm != 0) ? (n + 1) / 2 : n;
            setup(base, 16'(n), wm[0]);
            wreg(3'd0, 8'h02);
            rreg(3'd0, v); chk("R3 write code active", 32'(v), 2);
            for (int k = 0; k < nacc; k++) begin
               logic [7:0] b0, b1;
               logic [7:0] ia0, ia1;
               b0 = 8'(n * 31 + (k * stp) * 13 + wm * 5);
               b1 = 8'(n * 31 + (k * stp + 1) * 13 + wm * 5);
               ia0 = 8'(base + 16'(k * stp));
               ia1 = ia0 + 8'd1;
               model[ia0] = b0;
               if (wm != 0) model[ia1] = b1;
               dp_write({b1, b0});
            end
            expect_done(wm != 0 ? "R8 write" : "R4 write", base + 16'(nacc * stp));
            setup(base, 16'(n), wm[0]);
            wreg(3'd0, 8'h01);
            rreg(3'd0, v); chk("R3 read code active", 32'(v), 1);
            for (int k = 0; k < nacc; k++) begin
               logic [7:0] ia0;
               ia0 = 8'(base + 16'(k * stp));
               dp_read(d);
               if (wm != 0) chk("R7 word little-endian", 32'(d), 32'({model[ia0 + 8'd1], model[ia0]}));
               else         chk("R6 R2 byte prefetch", 32'(d), 32'({8'h00, model[ia0]}));
            end
            expect_done("R4 read", base + 16'(nacc * stp));
         end
      end

      // R7: word-written data read back bytewise in address order
      setup(16'h00C0, 16'd4, 1'b1);
      wreg(3'd0, 8'h02);
      dp_write(16'hB2A1); dp_write(16'hD4C3);
      expect_done("R7 word write", 16'h00C4);
      setup(16'h00C0, 16'd4, 1'b0);
      wreg(3'd0, 8'h01);
      dp_read(d); chk("R7 byte0", 32'(d), 32'h00A1);
      dp_read(d); chk("R7 byte1", 32'(d), 32'h00B2);
      dp_read(d); chk("R7 byte2", 32'(d), 32'h00C3);
      dp_read(d); chk("R7 byte3", 32'(d), 32'h00D4);
      expect_done("R7 byte read", 16'h00C4);

      // R5 write-one-to-clear
      setup(16'h0030, 16'd1, 1'b0);
      wreg(3'd0, 8'h02);
      dp_write(16'h005A);
      wreg(3'd1, 8'h00);
      rreg(3'd1, v); chk("R5 write 0 keeps flag", 32'(v), 1);
      wreg(3'd1, 8'h01);
      rreg(3'd1, v); chk("R5 write 1 clears flag", 32'(v), 0);
      chk("R5 done_irq low", 32'(done_irq), 0);

      // R9 idle strobes ignored
      setup(16'h0030, 16'd3, 1'b0);
      dp_write(16'h00AB);
      dp_read(d);
      rd_addr(w); chk("R9 addr unchanged", 32'(w), 32'h0030);
      rd_cnt(w);  chk("R9 count unchanged", 32'(w), 3);
      chk("R9 flag unchanged", 32'(done_irq), 0);
      setup(16'h0030, 16'd1, 1'b0);
      wreg(3'd0, 8'h01);
      dp_read(d); chk("R9 buffer unchanged", 32'(d), 32'h005A);
      wreg(3'd1, 8'h01);

      // R10 R12 R11: start during busy, register writes during busy, abort
      setup(16'h0050, 16'd4, 1'b0);
      wreg(3'd0, 8'h02);
      wreg(3'd0, 8'h01);
      rreg(3'd0, v); chk("R10 keeps write code", 32'(v), 2);
      wreg(3'd3, 8'h99); wreg(3'd5, 8'h09); wreg(3'd2, 8'h01);
      rd_addr(w); chk("R12 addr write ignored", 32'(w), 32'h0050);
      rd_cnt(w);  chk("R12 count write ignored", 32'(w), 4);
      rreg(3'd2, v); chk("R12 width write ignored", 32'(v), 0);
      dp_write(16'h0011);
      wreg(3'd0, 8'h03);
      rreg(3'd0, v); chk("R11 abort idles", 32'(v), 0);
      chk("R11 no flag", 32'(done_irq), 0);
      rd_addr(w); chk("R11 addr kept", 32'(w), 32'h0051);
      rd_cnt(w);  chk("R11 count kept", 32'(w), 3);

      // R13 wrap
      setup(16'hFFFE, 16'd4, 1'b0);
      wreg(3'd0, 8'h02);
      for (int k = 0; k < 4; k++) dp_write(16'(8'h70 + k));
      expect_done("R13 wrap", 16'h0002);

      // R14 zero-count start
      setup(16'h0010, 16'd0, 1'b0);
      wreg(3'd0, 8'h01);
      rreg(3'd0, v); chk("R14 cmd stays idle", 32'(v), 0);
      chk("R14 flag set", 32'(done_irq), 1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule